// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block takes a column offset and a page number and turns them into the ordered series of byte-wide address cycles that a NAND device expects. A controller pulses `start` with the column, the page, a valid flag for each, the page-size code, the page-address mask and a read flag. The block then presents one cycle at a time to a downstream bus engine, which owns the pin timing. Each cycle stays on the outputs until the engine pulses `step_done`.

The page-size code sets how many column cycles there are and which bits they carry. The page mask sets how many row cycles follow: the mask is shifted down one byte per row cycle until it reaches zero. A read on a large page ends with a read-confirm command strobe. One clock after the last step has been acknowledged, `done` pulses for a single cycle.

Top module: `nand_addr_seq`

## Requirements
- R1: When `col_valid` is set, the first step is an address cycle carrying `col_in[7:0]`.
- R2: With `page_size` = 2'b01 (2048-byte page), a second column cycle follows carrying `col_in[11:8]` in bits [3:0], with bits [7:4] zero.
- R3: With `page_size` = 2'b10 (4096-byte page), a second column cycle follows carrying `col_in[12:8]` in bits [4:0], with bits [7:5] zero.
- R4: With `page_size` = 2'b00 (512-byte page) or the spare code 2'b11, only the single low-byte column cycle is sent.
- R5: When `row_valid` is set, row cycles carry the page number one byte at a time, least significant byte first. After each cycle the page and the mask both shift right by 8, and the cycles stop when the shifted mask is zero. At least one row cycle is always sent, even with a zero mask.
- R6: A clear `col_valid` skips every column cycle, and a clear `row_valid` skips every row cycle. Column cycles always come before row cycles.
- R7: When `is_read` is set and `page_size` is 2'b01 or 2'b10, a command step with opcode 0x30 follows the address cycles. Writes and small pages get no command step.
- R8: Exactly one step is active at a time. Its strobe and byte hold steady until `step_done` is sampled high, and the next step appears in the following cycle.
- R9: `done` is high for exactly one cycle, one clock after the final `step_done`. If the job has no steps at all, it is high one clock after `start`. A `start` while a job is running is ignored, and `step_done` while idle is ignored.
- R10: Reset puts the outputs in this state: no strobe and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; sampled only when idle |
| col_valid | input | 1 | Job includes column cycles |
| col_in | input | COL_W | Column offset |
| row_valid | input | 1 | Job includes row cycles |
| row_in | input | ROW_W | Page number |
| row_mask | input | ROW_W | Page-address mask that sets the row cycle count |
| page_size | input | 2 | 00 = 512, 01 = 2048, 10 = 4096, 11 = treated as 512 |
| is_read | input | 1 | Job is a page read |
| step_done | input | 1 | Downstream engine has finished the current step |
| addr_stb | output | 1 | An address cycle is being presented |
| addr_byte | output | 8 | Address byte of the current cycle |
| cmd_stb | output | 1 | A command step is being presented |
| cmd_op | output | 8 | Command opcode (0x30 during the confirm step) |
| done | output | 1 | One-cycle job completion pulse |

## Verification
Random jobs cover every page-size code, with both valid flags toggled independently and masks of zero, one, two and three bytes, plus random masks. These separate the column-width rules from the row-count rule. Directed jobs isolate particular behaviours:
- A zero mask with a full page value shows that the byte count follows the mask and not the page.
- An all-ones column on each page size exposes any wrong high-column masking.
- A job with neither flag set, for both a read and a write, tells the immediate-done path apart from the confirm path.
- Random acknowledge delays, a stray start during a held step and a stray acknowledge while idle show that each step waits for its own handshake and that stray inputs are ignored.

// File: rtl/nas_pkg.sv
package nas_pkg;

    typedef enum logic [1:0] {
        PG_SMALL = 2'b00,
        PG_2K    = 2'b01,
        PG_4K    = 2'b10,
        PG_SPARE = 2'b11
    } pg_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COL_LO,
        ST_COL_HI,
        ST_ROW,
        ST_CONFIRM,
        ST_FINISH
    } seq_st_e;

    localparam logic [7:0] RD_CONFIRM_OP = 8'h30;

    typedef struct packed {
        logic     col_v;
        logic     row_v;
        logic     is_read;
        pg_size_e size;
    } job_t;

    function automatic logic is_large(pg_size_e s);
        return (s == PG_2K) || (s == PG_4K);
    endfunction

    function automatic logic [7:0] col_hi_mask(pg_size_e s);
        case (s)
            PG_2K:   return 8'h0F;
            PG_4K:   return 8'h1F;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nas_col_fmt.sv
module nas_col_fmt
    import nas_pkg::*;
#(
    parameter int COL_W = 13
) (
    input  logic [COL_W-1:0] col,
    input  pg_size_e         size,
    input  logic             sel_hi,
    output logic [7:0]       col_byte
);
    localparam int EXT_W = COL_W + 16;

    logic [EXT_W-1:0] col_ext;

    always_comb begin
        col_ext = {16'b0, col};
        if (sel_hi)
            col_byte = col_ext[15:8] & col_hi_mask(size);
        else
            col_byte = col_ext[7:0];
    end
endmodule

// File: rtl/nas_row_shift.sv
module nas_row_shift #(
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] mask_in,
    output logic [7:0]       row_byte,
    output logic             row_last
);
    localparam int BYTES = (ROW_W + 7) / 8;
    localparam int PAD_W = BYTES * 8;

    logic [PAD_W-1:0] row_q;
    logic [PAD_W-1:0] mask_q;
    logic [PAD_W-1:0] mask_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            mask_q <= '0;
        end else if (load) begin
            row_q  <= PAD_W'(row_in);
            mask_q <= PAD_W'(mask_in);
        end else if (shift) begin
            row_q  <= row_q >> 8;
            mask_q <= mask_next;
        end
    end

    always_comb begin
        mask_next = mask_q >> 8;
        row_byte  = row_q[7:0];
        row_last  = (mask_next == '0);
    end
endmodule

// File: rtl/nas_ctrl.sv
module nas_ctrl
    import nas_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    step_done,
    input  job_t    job_in,
    input  logic    row_last,
    output seq_st_e state,
    output job_t    job,
    output logic    row_load,
    output logic    row_shift
);
    seq_st_e st_q, st_d;
    job_t    job_q;

    function automatic seq_st_e after_row(job_t j);
        if (j.is_read && is_large(j.size)) return ST_CONFIRM;
        return ST_FINISH;
    endfunction

    function automatic seq_st_e after_col(job_t j);
        if (j.row_v) return ST_ROW;
        return after_row(j);
    endfunction

    function automatic seq_st_e first_step(job_t j);
        if (j.col_v) return ST_COL_LO;
        return after_col(j);
    endfunction

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:    if (start) st_d = first_step(job_in);
            ST_COL_LO:  if (step_done)
                            st_d = is_large(job_q.size) ? ST_COL_HI : after_col(job_q);
            ST_COL_HI:  if (step_done) st_d = after_col(job_q);
            ST_ROW:     if (step_done && row_last) st_d = after_row(job_q);
            ST_CONFIRM: if (step_done) st_d = ST_FINISH;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            job_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) job_q <= job_in;
        end
    end

    assign state     = st_q;
    assign job       = job_q;
    assign row_load  = (st_q == ST_IDLE) && start;
    assign row_shift = (st_q == ST_ROW) && step_done;
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nas_pkg::*;
#(
    parameter int COL_W = 13,
    parameter int ROW_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             col_valid,
    input  logic [COL_W-1:0] col_in,
    input  logic             row_valid,
    input  logic [ROW_W-1:0] row_in,
    input  logic [ROW_W-1:0] row_mask,
    input  logic [1:0]       page_size,
    input  logic             is_read,
    input  logic             step_done,
    output logic             addr_stb,
    output logic [7:0]       addr_byte,
    output logic             cmd_stb,
    output logic [7:0]       cmd_op,
    output logic             done
);
    job_t             job_in, job;
    seq_st_e          state;
    logic             row_load, row_shift, row_last;
    logic [7:0]       row_byte, col_byte;
    logic [COL_W-1:0] col_q;

    assign job_in = '{col_v: col_valid, row_v: row_valid,
                      is_read: is_read, size: pg_size_e'(page_size)};

    always_ff @(posedge clk) begin
        if (rst)
            col_q <= '0;
        else if (row_load)
            col_q <= col_in;
    end

    nas_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step_done (step_done),
        .job_in    (job_in),
        .row_last  (row_last),
        .state     (state),
        .job       (job),
        .row_load  (row_load),
        .row_shift (row_shift)
    );

    nas_col_fmt #(.COL_W(COL_W)) u_col (
        .col      (col_q),
        .size     (job.size),
        .sel_hi   (state == ST_COL_HI),
        .col_byte (col_byte)
    );

    nas_row_shift #(.ROW_W(ROW_W)) u_row (
        .clk      (clk),
        .rst      (rst),
        .load     (row_load),
        .shift    (row_shift),
        .row_in   (row_in),
        .mask_in  (row_mask),
        .row_byte (row_byte),
        .row_last (row_last)
    );

    always_comb begin
        addr_stb  = (state == ST_COL_LO) || (state == ST_COL_HI) || (state == ST_ROW);
        addr_byte = (state == ST_ROW) ? row_byte : (addr_stb ? col_byte : 8'h00);
        cmd_stb   = (state == ST_CONFIRM);
        cmd_op    = cmd_stb ? RD_CONFIRM_OP : 8'h00;
        done      = (state == ST_FINISH);
    end
endmodule

// File: rtl/nas_checker.sv
module nas_checker (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       step_done,
    input logic       addr_stb,
    input logic [7:0] addr_byte,
    input logic       cmd_stb,
    input logic [7:0] cmd_op,
    input logic       done
);
    // R8
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(addr_stb && cmd_stb));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        addr_stb && !step_done |=> addr_stb && $stable(addr_byte));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb && !step_done |=> cmd_stb && $stable(cmd_op));

    // R7
    confirm_last_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_stb && step_done |=> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(step_done || start));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !addr_stb && !cmd_stb);
endmodule

bind nand_addr_seq nas_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .step_done (step_done),
    .addr_stb  (addr_stb),
    .addr_byte (addr_byte),
    .cmd_stb   (cmd_stb),
    .cmd_op    (cmd_op),
    .done      (done)
);

// File: tb/sim_nand_addr_seq.sv
`timescale 1ns/1ps
module sim_nand_addr_seq;
    localparam int COL_W = 13;
    localparam int ROW_W = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             col_valid = 1'b0;
    logic [COL_W-1:0] col_in = '0;
    logic             row_valid = 1'b0;
    logic [ROW_W-1:0] row_in = '0;
    logic [ROW_W-1:0] row_mask = '0;
    logic [1:0]       page_size = 2'b00;
    logic             is_read = 1'b0;
    logic             step_done = 1'b0;
    logic             addr_stb, cmd_stb, done;
    logic [7:0]       addr_byte, cmd_op;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int    exp_n;
    bit    exp_cmd  [0:15];
    int    exp_byte [0:15];
    string exp_tag  [0:15];

    always #2 clk = ~clk;

    nand_addr_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .col_valid(col_valid),
        .col_in(col_in), .row_valid(row_valid), .row_in(row_in),
        .row_mask(row_mask), .page_size(page_size), .is_read(is_read),
        .step_done(step_done), .addr_stb(addr_stb), .addr_byte(addr_byte),
        .cmd_stb(cmd_stb), .cmd_op(cmd_op), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit c, input int b, input string tag);
        exp_cmd[exp_n]  = c;
        exp_byte[exp_n] = b;
        exp_tag[exp_n]  = tag;
        exp_n++;
    endtask

    // Expected step list from the requirements (R1..R7)
    task automatic build(input bit cv, input int col, input bit rv, input int row,
                         input int mask, input int sz, input bit rd);
        int r, m;
        exp_n = 0;
        if (cv) begin
            push(0, col & 'hFF, "R1");
            if (sz == 1) push(0, (col >> 8) & 'h0F, "R2");
            if (sz == 2) push(0, (col >> 8) & 'h1F, "R3");
        end
        if (rv) begin
            r = row; m = mask;
            do begin
                push(0, r & 'hFF, "R5");
                r = r >> 8; m = m >> 8;
            end while (m != 0);
        end
        if (rd && (sz == 1 || sz == 2)) push(1, 'h30, "R7");
    endtask

    task automatic run_job(input bit cv, input int col, input bit rv, input int row,
                           input int mask, input int sz, input bit rd, input bit poke);
        int hold;
        build(cv, col, rv, row, mask, sz, rd);
        @(negedge clk);
        col_valid = cv; col_in = col[COL_W-1:0]; row_valid = rv;
        row_in = row[ROW_W-1:0]; row_mask = mask[ROW_W-1:0];
        page_size = sz[1:0]; is_read = rd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        col_in = '1; row_in = '1;
        for (int i = 0; i < exp_n; i++) begin
            if (exp_cmd[i]) begin
                check(cmd_stb && !addr_stb && cmd_op == 8'h30, exp_tag[i], cmd_op, 'h30);
            end else begin
                check(addr_stb && !cmd_stb, {exp_tag[i], " R6 strobe"}, addr_stb, 1);
                check(addr_byte == exp_byte[i][7:0], exp_tag[i], addr_byte, exp_byte[i]);
            end
            check(!done, "R9 early done", done, 0);
            hold = $urandom_range(0, 2);
            for (int k = 0; k < hold; k++) begin
                if (poke && k == 0) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(exp_cmd[i] ? cmd_stb : (addr_stb && addr_byte == exp_byte[i][7:0]),
                      "R8 hold", addr_byte, exp_byte[i]);
            end
            step_done = 1'b1;
            @(negedge clk);
            step_done = 1'b0;
        end
        check(done && !addr_stb && !cmd_stb, "R9 done", done, 1);
        @(negedge clk);
        check(!done && !addr_stb && !cmd_stb, "R9 pulse", done, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!addr_stb && !cmd_stb && !done, "R10", {addr_stb, cmd_stb, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!addr_stb && !cmd_stb && !done, "R10", {addr_stb, cmd_stb, done}, 0);

        // R9: step_done while idle is ignored
        step_done = 1'b1;
        @(negedge clk);
        step_done = 1'b0;
        @(negedge clk);
        check(!addr_stb && !cmd_stb && !done, "R9 idle ack", {addr_stb, cmd_stb, done}, 0);

        // directed corners
        run_job(1, 'h1FFF, 1, 'hABCDEF, 0, 1, 1, 0);        // R2 R5 zero mask -> one row cycle
        run_job(1, 'h1FFF, 0, 0, 0, 2, 0, 0);               // R3 write no confirm
        run_job(1, 'h1FFF, 1, 'h123456, 'hFFFFFF, 0, 1, 0); // R4 small read, no confirm
        run_job(1, 'h1ABC, 1, 'h00FF01, 'h3FFFF, 3, 1, 0);  // R4 spare code
        run_job(0, 0, 0, 0, 0, 1, 1, 0);                    // R7 only confirm
        run_job(0, 0, 0, 0, 0, 2, 0, 0);                    // R9 no steps
        run_job(0, 'h155, 1, 'h0A0B0C, 'hFFFF, 2, 1, 1);    // R6 skip col, R9 start ignored

        for (int n = 0; n < 60; n++) begin
            int mk;
            case ($urandom_range(0, 4))
                0: mk = 0;
                1: mk = 'hFF;
                2: mk = 'hFFFF;
                3: mk = 'hFFFFFF;
                default: mk = int'($urandom_range(0, 'hFFFFFF));
            endcase
            run_job($urandom_range(0, 1), int'($urandom_range(0, 'h1FFF)),
                    $urandom_range(0, 1), int'($urandom_range(0, 'hFFFFFF)), mk,
                    int'($urandom_range(0, 3)), $urandom_range(0, 1),
                    ($urandom_range(0, 3) == 0));
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule